// File: doc/BRIEF.md
# Streaming Transmit Ready Throttle

This block sits between user logic and a serial link transmitter. User logic offers a packet stream of data beats with valid, ready, start-of-packet and end-of-packet, plus a command strobe that marks a beat as a user-defined command. The block drives ready back to the user so that transmit slots stay free for link overhead. That overhead is framing control words around packets, command words, alignment marker insertion and a periodic idle slot. Each overhead event books a fixed number of stall cycles. Bookings from events that overlap are added together rather than merged.

Accepted beats are forwarded one cycle later on a registered output port. Every stall cycle is reported on the same port as an overhead slot with a two-bit kind code. A mode input selects the periodic cadence: one slot every 17 cycles for PAM4 or every 33 cycles for NRZ. A second mode input enables the command feature, which is on in full mode and off in basic mode.

Top module: `tx_ready_throttle`

## Requirements
- R1: A beat is taken only in a cycle where `s_valid` and `s_ready` are both high. It appears on `m_valid`/`m_data`/`m_sop`/`m_eop` one cycle later, unchanged and in order. A beat held during stalls is forwarded exactly once.
- R2: An accepted beat with only `s_sop` books one stall cycle of kind 0 (control word). A beat with only `s_eop` also books one. A beat with both books two.
- R3: A cycle with `am_insert` high books four stall cycles of kind 1 (marker). This holds whether or not a beat is accepted in that cycle.
- R4: One stall cycle of kind 2 (periodic) is booked every 17 cycles when `mode_pam4`=1 and every 33 cycles when `mode_pam4`=0. The period counter runs freely through stalls.
- R5: With `mode_full`=1, an accepted beat with `s_cmd` and `s_sop` high books two stall cycles of kind 3 (command) in place of the start control word, and is forwarded with `m_cmd`=1. An end-of-packet on that beat still adds one kind-0 cycle.
- R6: With `mode_full`=0, `s_cmd` is ignored. The beat is treated as ordinary data, `m_cmd` stays 0 and no kind-3 stall is booked.
- R7: `s_ready` is low in every cycle where `s_valid` is low.
- R8: Stall bookings that overlap are summed, and `s_ready` stays low while any booking remains. Each stall cycle serves one booking in the priority order marker, control word, command, periodic. Each stall cycle appears one cycle later as `m_ovh`=1 with that kind on `m_ovh_kind` and no beat.
- R9: Synchronous reset `rst` clears all bookings, forces all outputs to 0 and restarts the period counter at zero. `s_ready` stays low in the first cycle after `rst` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_pam4 | input | 1 | 1: 17-cycle periodic slot, 0: 33-cycle |
| mode_full | input | 1 | 1: command beats enabled |
| am_insert | input | 1 | Alignment marker insertion strobe |
| s_valid | input | 1 | User beat valid |
| s_ready | output | 1 | Beat can be taken this cycle |
| s_data | input | DATA_W | User beat data |
| s_sop | input | 1 | Beat starts a packet |
| s_eop | input | 1 | Beat ends a packet |
| s_cmd | input | 1 | Beat is a user command (with s_sop) |
| m_valid | output | 1 | Forwarded beat valid |
| m_data | output | DATA_W | Forwarded data |
| m_sop | output | 1 | Forwarded start-of-packet |
| m_eop | output | 1 | Forwarded end-of-packet |
| m_cmd | output | 1 | Forwarded beat is a command |
| m_ovh | output | 1 | This slot is an overhead stall |
| m_ovh_kind | output | 2 | Stall kind: 0 control word, 1 marker, 2 periodic, 3 command |

## Verification
The hardest case to reach is a marker strobe that lands inside a framing stall that is already running. Reaching it also requires the periodic slot to fall elsewhere, so that the serving order can be read cleanly. Directed stimulus resets the block in NRZ mode to push the periodic slot more than 30 cycles away. It then completes a start-and-end beat and raises the marker strobe in the very next cycle. The expected slot order is one control word, four markers and then the second control word. Long random runs in both modes then mix held beats, command beats and sparse marker strobes, and compare every cycle against a bench model.

// File: rtl/txthr_pkg.sv
package txthr_pkg;
    typedef enum logic [1:0] {
        OVH_CW  = 2'd0,
        OVH_AM  = 2'd1,
        OVH_PER = 2'd2,
        OVH_CMD = 2'd3
    } ovh_kind_e;

    localparam int NUM_KINDS = 4;
    localparam int ADD_W     = 3;
endpackage

// File: rtl/txthr_period_gen.sv
module txthr_period_gen #(
    parameter int PER_PAM4 = 17,
    parameter int PER_NRZ  = 33
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_pam4,
    output logic tick
);
    localparam int PER_MAX = (PER_PAM4 > PER_NRZ) ? PER_PAM4 : PER_NRZ;
    localparam int CNT_W   = $clog2(PER_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pg_state_t;

    pg_state_t        st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = sel_pam4 ? CNT_W'(PER_PAM4 - 1) : CNT_W'(PER_NRZ - 1);
        tick  = (st_q.cnt >= limit);
        if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/txthr_stall_acct.sv
module txthr_stall_acct
    import txthr_pkg::*;
#(
    parameter int CTR_W = 6
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [NUM_KINDS-1:0][ADD_W-1:0]      add_amt,
    output logic                                 busy,
    output ovh_kind_e                            kind
);
    localparam int                 WIDE_W  = CTR_W + 2;
    localparam logic [WIDE_W-1:0]  CTR_MAX = WIDE_W'((1 << CTR_W) - 1);
    localparam ovh_kind_e PRIO [NUM_KINDS] = '{OVH_AM, OVH_CW, OVH_CMD, OVH_PER};

    typedef struct packed {
        logic [NUM_KINDS-1:0][CTR_W-1:0] ctr;
    } acct_state_t;

    acct_state_t          st_d, st_q;
    logic [NUM_KINDS-1:0] dec;
    logic [CTR_W-1:0]     nxt_ctr [NUM_KINDS];

    // pick the kind served in this stall cycle
    always_comb begin
        busy = 1'b0;
        kind = OVH_CW;
        for (int i = NUM_KINDS - 1; i >= 0; i--) begin
            if (st_q.ctr[PRIO[i]] != '0) begin
                busy = 1'b1;
                kind = PRIO[i];
            end
        end
        dec = '0;
        if (busy) begin
            dec[kind] = 1'b1;
        end
    end

    // per-kind saturating update
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        logic [WIDE_W-1:0] wide;
        always_comb begin
            wide = WIDE_W'(st_q.ctr[k]) + WIDE_W'(add_amt[k]) - WIDE_W'(dec[k]);
            if (wide > CTR_MAX) begin
                nxt_ctr[k] = CTR_MAX[CTR_W-1:0];
            end else begin
                nxt_ctr[k] = wide[CTR_W-1:0];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_KINDS; k++) begin
            st_d.ctr[k] = nxt_ctr[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/txthr_beat_reg.sv
module txthr_beat_reg
    import txthr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] data,
    input  logic              sop,
    input  logic              eop,
    input  logic              cmd,
    input  logic              stall,
    input  ovh_kind_e         stall_kind,
    output logic              o_valid,
    output logic [DATA_W-1:0] o_data,
    output logic              o_sop,
    output logic              o_eop,
    output logic              o_cmd,
    output logic              o_ovh,
    output logic [1:0]        o_kind
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              sop;
        logic              eop;
        logic              cmd;
        logic              ovh;
        logic [1:0]        kind;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d       = '0;
        st_d.valid = take;
        if (take) begin
            st_d.data = data;
            st_d.sop  = sop;
            st_d.eop  = eop;
            st_d.cmd  = cmd;
        end
        st_d.ovh = stall;
        if (stall) begin
            st_d.kind = stall_kind;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_valid = st_q.valid;
    assign o_data  = st_q.data;
    assign o_sop   = st_q.sop;
    assign o_eop   = st_q.eop;
    assign o_cmd   = st_q.cmd;
    assign o_ovh   = st_q.ovh;
    assign o_kind  = st_q.kind;
endmodule

// File: rtl/tx_ready_throttle.sv
module tx_ready_throttle
    import txthr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PER_PAM4 = 17,
    parameter int PER_NRZ  = 33,
    parameter int CW_CYC   = 1,
    parameter int AM_CYC   = 4,
    parameter int CMD_CYC  = 2,
    parameter int CTR_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_pam4,
    input  logic              mode_full,
    input  logic              am_insert,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_sop,
    input  logic              s_eop,
    input  logic              s_cmd,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    output logic              m_sop,
    output logic              m_eop,
    output logic              m_cmd,
    output logic              m_ovh,
    output logic [1:0]        m_ovh_kind
);
    typedef struct packed {
        logic run;
    } top_state_t;

    top_state_t                      st_d, st_q;
    logic                            per_tick;
    logic                            busy;
    ovh_kind_e                       kind;
    logic                            accept;
    logic                            is_cmd;
    logic [NUM_KINDS-1:0][ADD_W-1:0] add_amt;

    txthr_period_gen #(
        .PER_PAM4 (PER_PAM4),
        .PER_NRZ  (PER_NRZ)
    ) period_i (
        .clk      (clk),
        .rst      (rst),
        .sel_pam4 (mode_pam4),
        .tick     (per_tick)
    );

    txthr_stall_acct #(
        .CTR_W (CTR_W)
    ) acct_i (
        .clk     (clk),
        .rst     (rst),
        .add_amt (add_amt),
        .busy    (busy),
        .kind    (kind)
    );

    always_comb begin
        st_d     = st_q;
        st_d.run = 1'b1;
        s_ready  = st_q.run & ~busy & s_valid & ~rst;
        accept   = s_valid & s_ready;
        is_cmd   = accept & s_cmd & s_sop & mode_full;

        add_amt = '0;
        if (accept) begin
            if (is_cmd) begin
                add_amt[OVH_CMD] = ADD_W'(CMD_CYC);
            end else if (s_sop) begin
                add_amt[OVH_CW] = ADD_W'(CW_CYC);
            end
            if (s_eop) begin
                add_amt[OVH_CW] = add_amt[OVH_CW] + ADD_W'(CW_CYC);
            end
        end
        if (am_insert) begin
            add_amt[OVH_AM] = ADD_W'(AM_CYC);
        end
        if (per_tick) begin
            add_amt[OVH_PER] = ADD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    txthr_beat_reg #(
        .DATA_W (DATA_W)
    ) out_i (
        .clk        (clk),
        .rst        (rst),
        .take       (accept),
        .data       (s_data),
        .sop        (s_sop),
        .eop        (s_eop),
        .cmd        (is_cmd),
        .stall      (busy),
        .stall_kind (kind),
        .o_valid    (m_valid),
        .o_data     (m_data),
        .o_sop      (m_sop),
        .o_eop      (m_eop),
        .o_cmd      (m_cmd),
        .o_ovh      (m_ovh),
        .o_kind     (m_ovh_kind)
    );
endmodule

// File: rtl/txthr_checker.sv
module txthr_checker (
    input logic clk,
    input logic rst,
    input logic mode_full,
    input logic am_insert,
    input logic s_valid,
    input logic s_ready,
    input logic s_sop,
    input logic s_eop,
    input logic m_valid,
    input logic m_cmd,
    input logic m_ovh
);
    AST_BEAT_FORWARDED: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |=> m_valid); // R1

    AST_FRAME_WORD_STALL: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready && (s_sop || s_eop)) |=> !s_ready); // R2

    AST_MARKER_STALL: assert property (@(posedge clk) disable iff (rst)
        am_insert |=> !s_ready); // R3

    AST_BASIC_NO_CMD: assert property (@(posedge clk) disable iff (rst)
        m_cmd |-> $past(mode_full)); // R6

    AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !s_valid |-> !s_ready); // R7

    AST_SLOT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(m_valid && m_ovh)); // R8

    AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !s_ready); // R9
endmodule

bind tx_ready_throttle txthr_checker chk_i (.*);

// File: tb/tx_ready_throttle_tb_top.sv
`timescale 1ns/1ps
module tx_ready_throttle_tb_top;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_pam4 = 1'b0, mode_full = 1'b0, am_insert = 1'b0;
    logic          s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0, s_cmd = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic          s_ready;
    logic          m_valid, m_sop, m_eop, m_cmd, m_ovh;
    logic [DW-1:0] m_data;
    logic [1:0]    m_ovh_kind;

    always #2.5 clk = ~clk;

    tx_ready_throttle dut_i (
        .clk(clk), .rst(rst), .mode_pam4(mode_pam4), .mode_full(mode_full),
        .am_insert(am_insert), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_sop(s_sop), .s_eop(s_eop), .s_cmd(s_cmd),
        .m_valid(m_valid), .m_data(m_data), .m_sop(m_sop), .m_eop(m_eop),
        .m_cmd(m_cmd), .m_ovh(m_ovh), .m_ovh_kind(m_ovh_kind)
    );

    int checks = 0, failures = 0;

    // drive values for the next cycle
    logic d_rst = 1'b1, d_pam4 = 1'b0, d_full = 1'b0, d_am = 1'b0;
    logic d_valid = 1'b0, d_sop = 1'b0, d_eop = 1'b0, d_cmd = 1'b0;
    logic [DW-1:0] d_data = '0;

    // bench model state
    bit m_run = 0;
    int m_ctr [4];
    int m_cnt = 0;
    bit have_exp = 0;
    bit e_valid, e_sop, e_eop, e_cmd, e_ovh;
    logic [DW-1:0] e_data;
    int e_kind;
    bit last_acc, last_rdy;
    int cyc = 0;

    // observations
    int obs_cnt [4];
    int obs_seq [16];
    int obs_n = 0;
    bit obs_cmd = 0;
    int last_per = -1, per_gap = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int per_len(input bit pam4);
        return pam4 ? 17 : 33;
    endfunction

    // serving order: marker(1) > control word(0) > command(3) > periodic(2)
    function automatic int pick_kind(input int c0, input int c1, input int c2, input int c3);
        if (c1 > 0) return 1;
        if (c0 > 0) return 0;
        if (c3 > 0) return 3;
        return 2;
    endfunction

    task automatic clear_obs();
        for (int k = 0; k < 4; k++) obs_cnt[k] = 0;
        obs_n = 0; obs_cmd = 0; last_per = -1; per_gap = 0;
    endtask

    task automatic tick();
        bit busy, acc, isc, ptick;
        int kind;
        int add [4];
        @(negedge clk);
        if (have_exp) begin
            chk(m_valid == e_valid, "R1", "m_valid", m_valid, e_valid);
            if (e_valid) begin
                chk(m_data == e_data, "R1", "m_data", m_data, e_data);
                chk(m_sop == e_sop && m_eop == e_eop, "R1", "m_sop/eop",
                    {m_sop, m_eop}, {e_sop, e_eop});
                chk(m_cmd == e_cmd, "R5 R6", "m_cmd", m_cmd, e_cmd);
            end
            chk(m_ovh == e_ovh, "R8", "m_ovh", m_ovh, e_ovh);
            if (e_ovh) chk(int'(m_ovh_kind) == e_kind, "R8", "m_ovh_kind", m_ovh_kind, e_kind);
        end
        if (m_ovh === 1'b1) begin
            obs_cnt[m_ovh_kind]++;
            if (obs_n < 16) obs_seq[obs_n] = int'(m_ovh_kind);
            obs_n++;
            if (m_ovh_kind == 2'd2) begin
                if (last_per >= 0) per_gap = cyc - last_per;
                last_per = cyc;
            end
        end
        if (m_valid === 1'b1 && m_cmd === 1'b1) obs_cmd = 1;

        rst = d_rst; mode_pam4 = d_pam4; mode_full = d_full; am_insert = d_am;
        s_valid = d_valid; s_sop = d_sop; s_eop = d_eop; s_cmd = d_cmd; s_data = d_data;
        #1;
        busy = (m_ctr[0] + m_ctr[1] + m_ctr[2] + m_ctr[3]) > 0;
        kind = pick_kind(m_ctr[0], m_ctr[1], m_ctr[2], m_ctr[3]);
        acc  = !d_rst && m_run && !busy && d_valid;
        chk(s_ready == acc, "R7 R8 R9", "s_ready", s_ready, acc);
        last_rdy = s_ready;
        last_acc = acc;

        isc = acc && d_full && d_cmd && d_sop;
        e_valid = acc; e_data = d_data; e_sop = d_sop; e_eop = d_eop; e_cmd = isc;
        e_ovh = busy; e_kind = kind;
        if (d_rst) begin
            for (int k = 0; k < 4; k++) m_ctr[k] = 0;
            m_cnt = 0; m_run = 0;
            e_valid = 0; e_ovh = 0;
        end else begin
            for (int k = 0; k < 4; k++) add[k] = 0;
            if (acc) begin
                if (isc) add[3] = 2; else if (d_sop) add[0] = 1;
                if (d_eop) add[0] += 1;
            end
            if (d_am) add[1] = 4;
            ptick = (m_cnt >= per_len(d_pam4) - 1);
            if (ptick) add[2] = 1;
            m_cnt = ptick ? 0 : m_cnt + 1;
            for (int k = 0; k < 4; k++) begin
                m_ctr[k] = m_ctr[k] + add[k] - ((busy && kind == k) ? 1 : 0);
                if (m_ctr[k] > 63) m_ctr[k] = 63;
            end
            m_run = 1;
        end
        have_exp = 1;
        cyc++;
    endtask

    task automatic do_reset(input bit pam4, input bit full);
        d_rst = 1; d_pam4 = pam4; d_full = full; d_valid = 0; d_am = 0;
        repeat (3) tick();
        d_rst = 0;
    endtask

    task automatic send_beat(input logic [DW-1:0] dat, input bit sop, input bit eop, input bit cmd);
        int guard = 0;
        d_valid = 1; d_data = dat; d_sop = sop; d_eop = eop; d_cmd = cmd;
        do begin
            tick();
            guard++;
        end while (!last_acc && guard < 200);
        chk(last_acc, "R1", "beat accepted", guard, 1);
        d_valid = 0; d_sop = 0; d_eop = 0; d_cmd = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        for (int k = 0; k < 4; k++) m_ctr[k] = 0;

        // R9: reset state and release hold
        do_reset(1'b0, 1'b1);
        chk(m_valid == 0 && m_ovh == 0, "R9", "outputs in reset", {m_valid, m_ovh}, 0);
        d_valid = 1; d_data = 32'h1234; d_sop = 0; d_eop = 0;
        tick();
        chk(last_rdy == 0, "R9", "ready first cycle after release", last_rdy, 0);
        tick();
        chk(last_rdy == 1, "R9", "ready second cycle after release", last_rdy, 1);
        d_valid = 0;

        // R7: idle means not ready
        repeat (4) tick();
        chk(last_rdy == 0, "R7", "ready with valid low", last_rdy, 0);

        // R4: periodic cadence
        do_reset(1'b1, 1'b0); clear_obs();
        repeat (80) tick();
        chk(per_gap == 17, "R4", "PAM4 gap", per_gap, 17);
        do_reset(1'b0, 1'b0); clear_obs();
        repeat (110) tick();
        chk(per_gap == 33, "R4", "NRZ gap", per_gap, 33);

        // R2: framing stalls
        do_reset(1'b0, 1'b0); clear_obs();
        send_beat(32'hA1, 1, 0, 0); repeat (5) tick();
        chk(obs_cnt[0] == 1, "R2", "sop only CW slots", obs_cnt[0], 1);
        do_reset(1'b0, 1'b0); clear_obs();
        send_beat(32'hA2, 0, 1, 0); repeat (5) tick();
        chk(obs_cnt[0] == 1, "R2", "eop only CW slots", obs_cnt[0], 1);
        do_reset(1'b0, 1'b0); clear_obs();
        send_beat(32'hA3, 1, 1, 0); repeat (5) tick();
        chk(obs_cnt[0] == 2, "R2", "sop+eop CW slots", obs_cnt[0], 2);

        // R5: command in full mode
        do_reset(1'b0, 1'b1); clear_obs();
        send_beat(32'hC5, 1, 0, 1); repeat (5) tick();
        chk(obs_cnt[3] == 2 && obs_cnt[0] == 0, "R5", "cmd slots", obs_cnt[3], 2);
        chk(obs_cmd == 1, "R5", "m_cmd seen", obs_cmd, 1);

        // R6: command ignored in basic mode
        do_reset(1'b0, 1'b0); clear_obs();
        send_beat(32'hC6, 1, 0, 1); repeat (5) tick();
        chk(obs_cnt[3] == 0 && obs_cnt[0] == 1, "R6", "basic cmd slots", obs_cnt[3], 0);
        chk(obs_cmd == 0, "R6", "m_cmd seen", obs_cmd, 0);

        // R3: marker stall
        do_reset(1'b0, 1'b0); clear_obs();
        tick(); d_am = 1; tick(); d_am = 0;
        repeat (7) tick();
        chk(obs_cnt[1] == 4, "R3", "marker slots", obs_cnt[1], 4);

        // R8: marker inside framing stall, summed and ordered
        do_reset(1'b0, 1'b1); clear_obs();
        send_beat(32'hB8, 1, 1, 0);
        d_am = 1; tick(); d_am = 0;
        repeat (9) tick();
        chk(obs_n == 6, "R8", "total overlap slots", obs_n, 6);
        chk(obs_seq[0] == 0, "R8", "slot0 kind", obs_seq[0], 0);
        for (int i = 1; i < 5; i++) chk(obs_seq[i] == 1, "R8", "marker slot kind", obs_seq[i], 1);
        chk(obs_seq[5] == 0, "R8", "slot5 kind", obs_seq[5], 0);

        // random phases, both modes (R1..R8 via per-cycle model compare)
        begin
            int unused_seed = $urandom(32'h5EED_0007);
            for (int ph = 0; ph < 2; ph++) begin
                do_reset(ph == 1, ph == 0);
                for (int n = 0; n < 3000; n++) begin
                    if (!d_valid && ($urandom % 3) == 0) begin
                        d_valid = 1; d_data = $urandom;
                        d_sop = $urandom % 2; d_eop = $urandom % 2; d_cmd = ($urandom % 4) == 0;
                    end
                    d_am = ($urandom % 40) == 0;
                    tick();
                    if (last_acc) begin
                        d_valid = 0; d_sop = 0; d_eop = 0; d_cmd = 0;
                    end
                end
                d_am = 0; d_valid = 0;
                repeat (20) tick();
            end
            if (unused_seed == 0) checks = checks + 0;
        end

        finish_run();
    end
endmodule